// File: doc/BRIEF.md
# Relative Branch and Link Executor

This unit executes the PC-relative branch instructions of a 32-bit pipelined core. Each cycle it may accept one instruction word together with the fetch PC and the four arithmetic flags (negative, zero, carry, overflow). The fetch PC is two instruction words ahead of the instruction being executed. The unit checks that the word belongs to the branch class and evaluates its condition against the flags. When the branch is taken, the unit forms the target address and, for the linking form, a return address for register 14. It then flushes the pipeline and drives a three-beat refill of the fetch stream.

A branch that is not taken retires in the cycle it is accepted and leaves no trace on the outputs. A taken branch makes the unit busy for three cycles. The first cycle issues a non-sequential fetch of the target. The next two cycles issue sequential fetches of the two words after the target. Any word presented while the unit is busy is ignored. All outputs are registered, so results appear in the cycle after acceptance.

Top module: `branch_link_unit`

## Requirements
- R1: A word is a branch only when bits 27:25 equal 3'b101. Any other value there gives no branch_taken, flush, link_we, fetch_req or busy.
- R2: The condition is bits 31:28, evaluated over the flags N, Z, C and V. 0 Z set; 1 Z clear; 2 C set; 3 C clear; 4 N set; 5 N clear; 6 V set; 7 V clear; 8 C set and Z clear; 9 C clear or Z set; 10 N equals V; 11 N differs from V; 12 Z clear and N equals V; 13 Z set or N differs from V; 14 always; 15 never.
- R3: The target is pc plus the 24-bit two's-complement offset in bits 23:0, sign-extended and multiplied by 4, taken modulo 2^32. The target appears on target_addr and fetch_addr in the cycle after acceptance.
- R4: link_we pulses together with branch_taken only when bit 24 is 1. link_data then equals pc minus 4 with bits 1:0 forced to zero.
- R5: A branch-class word whose condition fails gives no flush, no link write and no busy. A new word is accepted in the very next cycle.
- R6: A taken branch raises branch_taken and flush for exactly one cycle, the cycle after acceptance.
- R7: A taken branch drives these fetches. Cycle 1 after acceptance: fetch_req=1, fetch_seq=0, fetch_addr=target. Cycles 2 and 3: fetch_seq=1 with target+4 and then target+8. busy is high in cycles 1 to 3 and low in cycle 4.
- R8: instr_valid is ignored while busy is high. No second branch starts and the refill addresses are unchanged.
- R9: After a synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is presented |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Fetch PC, 8 bytes past the instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| branch_taken | output | 1 | One-cycle pulse for a taken branch |
| flush | output | 1 | One-cycle pipeline flush request |
| target_addr | output | 32 | Target of the last taken branch |
| link_we | output | 1 | One-cycle write strobe for register 14 |
| link_data | output | 32 | Return address to write |
| fetch_req | output | 1 | Refill fetch request |
| fetch_seq | output | 1 | 1 = sequential fetch, 0 = non-sequential |
| fetch_addr | output | 32 | Refill fetch address |
| busy | output | 1 | Refill sequence in progress |

## Verification
The hardest case to reach from the ports is a valid word arriving while the refill is still running. A correct unit shows nothing for it, so the fault only becomes visible as disturbed refill addresses or a second branch pulse. To reach it, the bench keeps instr_valid high during all three busy cycles of many taken branches. The word it holds there is an always-taken branch with a different target. The bench then checks that the target+4 and target+8 beats are unchanged and that no pulse follows. The condition sweep covers all 16 codes against all 16 flag patterns, in both the plain and the linking form. The offset extremes and an address wrap at the top of memory are exercised separately.

// File: rtl/bl_pkg.sv
package bl_pkg;

  localparam logic [2:0] BR_CLASS = 3'b101;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_code_e;

  typedef struct packed {
    logic [3:0]  cond;
    logic [2:0]  cls;
    logic        link;
    logic [23:0] ofs;
  } br_word_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/bl_cond_eval.sv
module bl_cond_eval
  import bl_pkg::*;
(
  input  logic [3:0] cond,
  input  flags_t     flg,
  output logic       pass
);

  logic nv_eq;

  always_comb begin
    nv_eq = (flg.n == flg.v);
    case (cond_code_e'(cond))
      CC_EQ:   pass = flg.z;
      CC_NE:   pass = !flg.z;
      CC_CS:   pass = flg.c;
      CC_CC:   pass = !flg.c;
      CC_MI:   pass = flg.n;
      CC_PL:   pass = !flg.n;
      CC_VS:   pass = flg.v;
      CC_VC:   pass = !flg.v;
      CC_HI:   pass = flg.c && !flg.z;
      CC_LS:   pass = !flg.c || flg.z;
      CC_GE:   pass = nv_eq;
      CC_LT:   pass = !nv_eq;
      CC_GT:   pass = !flg.z && nv_eq;
      CC_LE:   pass = flg.z || !nv_eq;
      CC_AL:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/bl_addr_calc.sv
module bl_addr_calc #(
  parameter int ADDR_W         = 32,
  parameter int OFS_W          = 24,
  parameter int INSN_BYTES     = 4,
  parameter int PREFETCH_WORDS = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] link
);

  localparam int SHIFT     = $clog2(INSN_BYTES);
  localparam int EXT_W     = ADDR_W - OFS_W - SHIFT;
  localparam int LINK_BACK = (PREFETCH_WORDS - 1) * INSN_BYTES;

  logic [ADDR_W-1:0] ofs_bytes;
  logic [ADDR_W-1:0] ret_raw;

  always_comb begin
    ofs_bytes = {{EXT_W{ofs[OFS_W-1]}}, ofs, {SHIFT{1'b0}}};
    target    = pc + ofs_bytes;
    ret_raw   = pc - ADDR_W'(LINK_BACK);
    link      = ret_raw & ~ADDR_W'(3);
  end

endmodule

// File: rtl/bl_refill_seq.sv
module bl_refill_seq #(
  parameter int ADDR_W       = 32,
  parameter int INSN_BYTES   = 4,
  parameter int REFILL_BEATS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              fire_link,
  input  logic [ADDR_W-1:0] new_target,
  input  logic [ADDR_W-1:0] new_link,
  output logic              branch_taken,
  output logic              flush,
  output logic [ADDR_W-1:0] target_addr,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_data,
  output logic              fetch_req,
  output logic              fetch_seq,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              busy
);

  localparam int BEAT_W = $clog2(REFILL_BEATS + 1);

  logic [BEAT_W-1:0] beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      branch_taken <= 1'b0;
      flush        <= 1'b0;
      target_addr  <= '0;
      link_we      <= 1'b0;
      link_data    <= '0;
      fetch_req    <= 1'b0;
      fetch_seq    <= 1'b0;
      fetch_addr   <= '0;
      busy         <= 1'b0;
      beat         <= '0;
    end else begin
      branch_taken <= 1'b0;
      flush        <= 1'b0;
      link_we      <= 1'b0;
      if (fire && !busy) begin
        branch_taken <= 1'b1;
        flush        <= 1'b1;
        target_addr  <= new_target;
        link_we      <= fire_link;
        if (fire_link) link_data <= new_link;
        fetch_req    <= 1'b1;
        fetch_seq    <= 1'b0;
        fetch_addr   <= new_target;
        busy         <= 1'b1;
        beat         <= BEAT_W'(1);
      end else if (busy) begin
        if (beat == BEAT_W'(REFILL_BEATS)) begin
          busy      <= 1'b0;
          fetch_req <= 1'b0;
          fetch_seq <= 1'b0;
          beat      <= '0;
        end else begin
          fetch_seq  <= 1'b1;
          fetch_addr <= fetch_addr + ADDR_W'(INSN_BYTES);
          beat       <= beat + BEAT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
  import bl_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int INSN_W         = 32,
  parameter int OFS_W          = 24,
  parameter int INSN_BYTES     = 4,
  parameter int PREFETCH_WORDS = 2,
  parameter int REFILL_BEATS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [INSN_W-1:0] instr,
  input  logic [ADDR_W-1:0] pc,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic              branch_taken,
  output logic              flush,
  output logic [ADDR_W-1:0] target_addr,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_data,
  output logic              fetch_req,
  output logic              fetch_seq,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              busy
);

  br_word_t          word;
  flags_t            flg;
  logic              cond_ok;
  logic              is_branch;
  logic              fire;
  logic [ADDR_W-1:0] calc_target;
  logic [ADDR_W-1:0] calc_link;

  always_comb begin
    word      = br_word_t'(instr);
    flg       = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};
    is_branch = (word.cls == BR_CLASS);
    fire      = instr_valid && !busy && is_branch && cond_ok;
  end

  bl_cond_eval u_cond (
    .cond (word.cond),
    .flg  (flg),
    .pass (cond_ok)
  );

  bl_addr_calc #(
    .ADDR_W         (ADDR_W),
    .OFS_W          (OFS_W),
    .INSN_BYTES     (INSN_BYTES),
    .PREFETCH_WORDS (PREFETCH_WORDS)
  ) u_addr (
    .pc     (pc),
    .ofs    (word.ofs[OFS_W-1:0]),
    .target (calc_target),
    .link   (calc_link)
  );

  bl_refill_seq #(
    .ADDR_W       (ADDR_W),
    .INSN_BYTES   (INSN_BYTES),
    .REFILL_BEATS (REFILL_BEATS)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .fire         (fire),
    .fire_link    (word.link),
    .new_target   (calc_target),
    .new_link     (calc_link),
    .branch_taken (branch_taken),
    .flush        (flush),
    .target_addr  (target_addr),
    .link_we      (link_we),
    .link_data    (link_data),
    .fetch_req    (fetch_req),
    .fetch_seq    (fetch_seq),
    .fetch_addr   (fetch_addr),
    .busy         (busy)
  );

endmodule

// File: rtl/bl_checker.sv
module bl_checker #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              branch_taken,
  input logic              flush,
  input logic [ADDR_W-1:0] target_addr,
  input logic              link_we,
  input logic [ADDR_W-1:0] link_data,
  input logic              fetch_req,
  input logic              fetch_seq,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              busy
);

  // R6
  taken_flush_chk: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> flush && fetch_req && !fetch_seq);

  // R4
  link_only_taken_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> branch_taken && (link_data[1:0] == 2'b00));

  // R3
  target_match_chk: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> fetch_addr == target_addr);

  // R7
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_seq) |-> fetch_addr == $past(fetch_addr) + ADDR_W'(INSN_BYTES));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> branch_taken);

  // R7
  fetch_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> busy);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    branch_taken |=> !branch_taken);

endmodule

bind branch_link_unit bl_checker #(
  .ADDR_W     (ADDR_W),
  .INSN_BYTES (INSN_BYTES)
) u_bl_chk (
  .clk          (clk),
  .rst          (rst),
  .branch_taken (branch_taken),
  .flush        (flush),
  .target_addr  (target_addr),
  .link_we      (link_we),
  .link_data    (link_data),
  .fetch_req    (fetch_req),
  .fetch_seq    (fetch_seq),
  .fetch_addr   (fetch_addr),
  .busy         (busy)
);

// File: tb/test_branch_link_unit.sv
module test_branch_link_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic        branch_taken, flush, link_we, fetch_req, fetch_seq, busy;
  logic [31:0] target_addr, link_data, fetch_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_link_unit i_branch_link_unit (
    .clk (clk), .rst (rst), .instr_valid (instr_valid), .instr (instr),
    .pc (pc), .flag_n (flag_n), .flag_z (flag_z), .flag_c (flag_c),
    .flag_v (flag_v), .branch_taken (branch_taken), .flush (flush),
    .target_addr (target_addr), .link_we (link_we), .link_data (link_data),
    .fetch_req (fetch_req), .fetch_seq (fetch_seq), .fetch_addr (fetch_addr),
    .busy (busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit cond_expect(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return cy;
      4'h3: return !cy;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return cy && !z;
      4'h9: return !cy || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_branch(input logic [3:0] c, input logic [3:0] f,
                            input bit lnk, input logic [23:0] ofs,
                            input logic [31:0] pcv, input bit jam);
    bit          pass;
    logic [31:0] tgt, ret;
    pass = cond_expect(c, f);
    tgt  = pcv + {{6{ofs[23]}}, ofs, 2'b00};
    ret  = (pcv - 32'd4) & 32'hFFFF_FFFC;
    @(negedge clk);
    instr = {c, 3'b101, lnk, ofs};
    pc = pcv;
    {flag_n, flag_z, flag_c, flag_v} = f;
    instr_valid = 1'b1;
    @(negedge clk);
    if (jam && pass) begin
      instr = {4'hE, 3'b101, 1'b1, 24'h000400};
      pc = pcv ^ 32'h0001_0000;
    end else begin
      instr_valid = 1'b0;
    end
    // R2 condition decision
    chk(branch_taken == pass, "R2", "branch_taken", 32'(branch_taken), 32'(pass));
    if (pass) begin
      // R6 flush pulse, R3 target, R7 first beat, R4 link
      chk(flush == 1'b1, "R6", "flush", 32'(flush), 32'd1);
      chk(target_addr == tgt, "R3", "target_addr", target_addr, tgt);
      chk(fetch_req && !fetch_seq && fetch_addr == tgt, "R7", "beat1 addr",
          fetch_addr, tgt);
      chk(link_we == lnk, "R4", "link_we", 32'(link_we), 32'(lnk));
      if (lnk) chk(link_data == ret, "R4", "link_data", link_data, ret);
      chk(busy == 1'b1, "R7", "busy beat1", 32'(busy), 32'd1);
      @(negedge clk);
      chk(fetch_req && fetch_seq && fetch_addr == tgt + 32'd4, "R7",
          "beat2 addr", fetch_addr, tgt + 32'd4);
      chk(!branch_taken && !flush && !link_we, "R6", "pulse ends",
          32'(branch_taken), 32'd0);
      @(negedge clk);
      chk(fetch_req && fetch_seq && fetch_addr == tgt + 32'd8, "R7",
          "beat3 addr", fetch_addr, tgt + 32'd8);
      chk(busy == 1'b1, "R8", "busy beat3", 32'(busy), 32'd1);
      @(negedge clk);
      instr_valid = 1'b0;
      chk(!busy && !fetch_req, "R7", "busy drop", 32'(busy), 32'd0);
      @(negedge clk);
      // R8 the word held during busy must not have started a branch
      chk(!branch_taken && !busy, "R8", "no late start", 32'(branch_taken), 32'd0);
    end else begin
      // R5 failed condition leaves no trace
      chk(!flush && !link_we && !busy && !fetch_req, "R5", "quiet",
          {28'd0, flush, link_we, busy, fetch_req}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!branch_taken && !flush && !link_we && !fetch_req && !fetch_seq && !busy
        && target_addr == 0 && link_data == 0 && fetch_addr == 0,
        "R9", "reset outputs", fetch_addr, 32'd0);
    rst = 1'b0;

    // R2 full condition x flag sweep, both link forms
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        for (int l = 0; l < 2; l++)
          run_branch(4'(c), 4'(f), l[0], 24'(c * 4099 + f * 17), 32'h0000_8008 + 32'(f * 256),
                     (f % 3) == 0);

    // R3 offset extremes and wrap
    run_branch(4'hE, 4'h0, 1'b0, 24'h7FFFFF, 32'h0200_0008, 1'b0);
    run_branch(4'hE, 4'h0, 1'b0, 24'h800000, 32'h0200_0008, 1'b0);
    run_branch(4'hE, 4'h0, 1'b1, 24'hFFFFFF, 32'h0000_1000, 1'b1);
    run_branch(4'hE, 4'h0, 1'b0, 24'h000002, 32'hFFFF_FFF8, 1'b0);
    run_branch(4'hE, 4'h0, 1'b0, 24'h000000, 32'h0000_0008, 1'b0);
    // R4 misaligned pc: link low bits cleared
    run_branch(4'hE, 4'h0, 1'b1, 24'h000010, 32'h0000_1003, 1'b0);

    // R1 non-branch classes ignored
    for (int k = 0; k < 8; k++) begin
      if (k == 5) continue;
      @(negedge clk);
      instr = {4'hE, 3'(k), 1'b1, 24'h000100};
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      chk(!branch_taken && !flush && !link_we && !fetch_req && !busy, "R1",
          "non-branch class", 32'(k), 32'd0);
    end

    // R5 failed condition followed at once by an accepted branch
    @(negedge clk);
    instr = {4'hF, 3'b101, 1'b0, 24'h000100};
    pc = 32'h0000_4008;
    instr_valid = 1'b1;
    @(negedge clk);
    instr = {4'hE, 3'b101, 1'b0, 24'h000001};
    @(negedge clk);
    instr_valid = 1'b0;
    chk(branch_taken && fetch_addr == 32'h0000_400C, "R5", "next accepted",
        fetch_addr, 32'h0000_400C);
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule